// File: doc/BRIEF.md
# Configuration Set Loader

This block moves one configuration set out of a byte-wide nonvolatile memory and into a bank of control registers. A load command arrives as two argument bytes on a byte-wide command strobe. Together the two bytes give a 16-bit start address. If the whole 32-byte set lies inside the permitted memory window, the engine becomes busy. It then reads the 32 bytes one after another and writes them to register sub-addresses 10h to 2Fh. When the copy ends it pulses done.

The register at sub-address 10h is never written. Its source byte is still fetched, so the order of memory reads stays unchanged. Any start address that would read outside the window of 30h to 7Fh is refused. A refused command raises a one-cycle error pulse, and no memory read or register write follows it. The window holds two full sets plus one extra 16-byte block of user data.

The memory, the command decoder and the register bank are outside this block. The register bank keeps its reset defaults until a valid command overwrites them.

Top module: `cfg_loader`

## Requirements
- R1: After reset `busy`, `done`, `error`, `mem_rd` and `reg_we` are low. They stay low, and no register is written, until a complete command is received.
- R2: A command is two bytes presented with `cmd_valid`. The first byte accepted is the low byte of the start address and the second is the high byte. The second byte completes the command.
- R3: A start address below 30h, or one whose last byte (start+31) lies above 7Fh, is rejected. `error` is high for exactly the one cycle after the second byte, `busy` stays low, and no memory read and no register write take place.
- R4: For an accepted command, memory is read at start, start+1, ..., start+31 in that order. Only one read is outstanding at a time, and every read address lies in 30h..7Fh.
- R5: Memory byte start+i is written to register sub-address 10h+i, for i from 1 to 31. Each write happens in the cycle after `mem_dvalid` returned that byte.
- R6: The byte at offset 0 is read but never written, so register 10h keeps its previous value. Exactly 31 register writes occur per accepted command, all within 11h..2Fh.
- R7: `busy` rises in the cycle after the accepting byte and stays high until the one-cycle `done` pulse. It falls in the cycle after `done`.
- R8: Bytes presented on `cmd_valid` while `busy` is high are discarded. They neither start a command nor leave a partial argument behind, so the next command after `done` is decoded from its own two bytes.
- R9: The window edges are inclusive. Start 30h and start 60h (last byte 7Fh) are accepted, while 2Fh and 61h are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command argument byte strobe |
| cmd_byte | input | 8 | Command argument byte, low byte first |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | One-cycle memory read request |
| mem_dvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 8 | Memory read data |
| reg_addr | output | 6 | Register sub-address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write enable |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection pulse |

## Verification
The assertions check the per-cycle rules on every cycle. Reads stay inside the window, writes stay inside 11h..2Fh and always follow a data-valid cycle, `done` lasts one cycle, `busy` ends only through `done`, and `error` never overlaps `busy`. Argument bytes that arrive while busy must not change the capture state. Only the bench scenarios can show the end-to-end facts. These are that each register holds the right memory byte, that the read sequence is complete and in order, that register 10h keeps its default, and that the window edges and argument byte order are honoured. The bench also shows that discarded bytes do not disturb the next command when memory latency varies.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WAIT,
      ST_WRITE,
      ST_DONE
   } ld_state_t;
endpackage

// File: rtl/cfg_arg_capture.sv
module cfg_arg_capture #(
   parameter int ADDR_W    = 16,
   parameter int BYTE_W    = 8,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              block,
   output logic              go,
   output logic [ADDR_W-1:0] start_addr
);
   if (ADDR_W != 2 * BYTE_W) begin : g_bad_width
      $error("cfg_arg_capture: ADDR_W must be twice BYTE_W");
   end

   logic              have_first;
   logic [BYTE_W-1:0] first_q;
   logic              take;

   assign take = byte_valid && !block;
   assign go   = take && have_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_first <= 1'b0;
         first_q    <= '0;
      end else if (take) begin
         if (!have_first) begin
            first_q    <= byte_in;
            have_first <= 1'b1;
         end else begin
            have_first <= 1'b0;
         end
      end
   end

   if (LOW_FIRST) begin : g_low_first
      assign start_addr = {byte_in, first_q};
   end else begin : g_high_first
      assign start_addr = {first_q, byte_in};
   end

   AST_BUSY_BYTE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && block) |=> ($stable(have_first) && $stable(first_q))); // R8
endmodule

// File: rtl/cfg_window_check.sv
module cfg_window_check #(
   parameter int ADDR_W  = 16,
   parameter int WIN_LO  = 'h30,
   parameter int WIN_HI  = 'h7F,
   parameter int SET_LEN = 32
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              ok
);
   localparam int EXT_W = ADDR_W + 1;

   logic [EXT_W-1:0] last_byte;

   always_comb begin
      last_byte = {1'b0, addr} + EXT_W'(SET_LEN - 1);
      ok        = (addr >= ADDR_W'(WIN_LO)) && (last_byte <= EXT_W'(WIN_HI));
   end
endmodule

// File: rtl/cfg_copy_seq.sv
module cfg_copy_seq
   import cfg_loader_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int BYTE_W     = 8,
   parameter int RADDR_W    = 6,
   parameter int SET_LEN    = 32,
   parameter int DST_BASE   = 'h10,
   parameter bit SKIP_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic               ok,
   input  logic [ADDR_W-1:0]  start_addr,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_rd,
   input  logic               mem_dvalid,
   input  logic [BYTE_W-1:0]  mem_rdata,
   output logic [RADDR_W-1:0] reg_addr,
   output logic [BYTE_W-1:0]  reg_wdata,
   output logic               reg_we,
   output logic               busy,
   output logic               done,
   output logic               error
);
   localparam int IDX_W = $clog2(SET_LEN);

   ld_state_t         state;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;
   logic [BYTE_W-1:0] data_q;
   logic              err_q;
   logic              last;
   logic              write_ok;

   assign last = (idx_q == IDX_W'(SET_LEN - 1));

   if (SKIP_FIRST) begin : g_skip_first
      assign write_ok = (idx_q != '0);
   end else begin : g_copy_all
      assign write_ok = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         base_q <= '0;
         idx_q  <= '0;
         data_q <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  if (ok) begin
                     base_q <= start_addr;
                     idx_q  <= '0;
                     state  <= ST_READ;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            ST_READ: state <= ST_WAIT;
            ST_WAIT: begin
               if (mem_dvalid) begin
                  data_q <= mem_rdata;
                  state  <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (last) begin
                  state <= ST_DONE;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  state <= ST_READ;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_addr  = base_q + ADDR_W'(idx_q);
   assign mem_rd    = (state == ST_READ);
   assign reg_addr  = RADDR_W'(DST_BASE) + RADDR_W'(idx_q);
   assign reg_wdata = data_q;
   assign reg_we    = (state == ST_WRITE) && write_ok;
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);
   assign error     = err_q;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!reg_we && !mem_rd)); // R1
   AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !busy); // R3
   AST_WE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(mem_dvalid)); // R5
   AST_DST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> ((reg_addr > RADDR_W'(DST_BASE)) &&
                  (reg_addr <= RADDR_W'(DST_BASE + SET_LEN - 1)))); // R6
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done)); // R7
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
   parameter int ADDR_W     = 16,
   parameter int BYTE_W     = 8,
   parameter int RADDR_W    = 6,
   parameter int SET_LEN    = 32,
   parameter int DST_BASE   = 'h10,
   parameter int WIN_LO     = 'h30,
   parameter int WIN_HI     = 'h7F,
   parameter bit LOW_FIRST  = 1'b1,
   parameter bit SKIP_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [BYTE_W-1:0]  cmd_byte,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_rd,
   input  logic               mem_dvalid,
   input  logic [BYTE_W-1:0]  mem_rdata,
   output logic [RADDR_W-1:0] reg_addr,
   output logic [BYTE_W-1:0]  reg_wdata,
   output logic               reg_we,
   output logic               busy,
   output logic               done,
   output logic               error
);
   if (SET_LEN < 2) begin : g_bad_len
      $error("cfg_loader: SET_LEN must be at least 2");
   end
   if (DST_BASE + SET_LEN > (1 << RADDR_W)) begin : g_bad_dst
      $error("cfg_loader: destination range exceeds register address space");
   end
   if (WIN_HI < WIN_LO + SET_LEN - 1) begin : g_bad_win
      $error("cfg_loader: source window smaller than one set");
   end

   logic              go;
   logic              ok;
   logic [ADDR_W-1:0] start_addr;

   cfg_arg_capture #(
      .ADDR_W    (ADDR_W),
      .BYTE_W    (BYTE_W),
      .LOW_FIRST (LOW_FIRST)
   ) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (cmd_valid),
      .byte_in    (cmd_byte),
      .block      (busy),
      .go         (go),
      .start_addr (start_addr)
   );

   cfg_window_check #(
      .ADDR_W  (ADDR_W),
      .WIN_LO  (WIN_LO),
      .WIN_HI  (WIN_HI),
      .SET_LEN (SET_LEN)
   ) i_window (
      .addr (start_addr),
      .ok   (ok)
   );

   cfg_copy_seq #(
      .ADDR_W     (ADDR_W),
      .BYTE_W     (BYTE_W),
      .RADDR_W    (RADDR_W),
      .SET_LEN    (SET_LEN),
      .DST_BASE   (DST_BASE),
      .SKIP_FIRST (SKIP_FIRST)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .ok         (ok),
      .start_addr (start_addr),
      .mem_addr   (mem_addr),
      .mem_rd     (mem_rd),
      .mem_dvalid (mem_dvalid),
      .mem_rdata  (mem_rdata),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_we     (reg_we),
      .busy       (busy),
      .done       (done),
      .error      (error)
   );

   AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> ((mem_addr >= ADDR_W'(WIN_LO)) && (mem_addr <= ADDR_W'(WIN_HI)))); // R4
endmodule

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
   localparam logic [7:0] DEF_VAL = 8'hC3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_byte = '0;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic        mem_dvalid = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic [5:0]  reg_addr;
   logic [7:0]  reg_wdata;
   logic        reg_we;
   logic        busy;
   logic        done;
   logic        error;

   int errors = 0;
   int checks = 0;

   logic [7:0]  mem [0:255];
   logic [7:0]  regs [0:63];
   logic [15:0] rd_log [0:63];
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   logic        init_req = 1'b0;

   always #2 clk = ~clk;

   cfg_loader i_cfg_loader (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_byte   (cmd_byte),
      .mem_addr   (mem_addr),
      .mem_rd     (mem_rd),
      .mem_dvalid (mem_dvalid),
      .mem_rdata  (mem_rdata),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_we     (reg_we),
      .busy       (busy),
      .done       (done),
      .error      (error)
   );

   function automatic bit win_ok(input logic [15:0] a);
      return (int'(a) >= 'h30) && (int'(a) + 31 <= 'h7F);
   endfunction

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // register bank model and write monitor
   always @(negedge clk) begin
      if (init_req) begin
         for (int i = 0; i < 64; i++) regs[i] = DEF_VAL;
         wr_cnt = 0;
      end else if (reg_we) begin
         regs[reg_addr] = reg_wdata;
         wr_cnt++;
      end
   end

   // memory model with varying latency
   initial begin
      forever begin
         @(negedge clk);
         if (init_req) rd_cnt = 0;
         if (mem_rd) begin
            if (rd_cnt < 64) rd_log[rd_cnt] = mem_addr;
            rd_cnt++;
            repeat (1 + int'($urandom % 3)) @(negedge clk);
            mem_dvalid = 1'b1;
            mem_rdata  = mem[mem_addr[7:0]];
            @(negedge clk);
            mem_dvalid = 1'b0;
         end
      end
   end

   task automatic run_cmd(input logic [15:0] a, input bit inject);
      bit ok;
      bit seen_done;
      int bad;
      int first_bad;
      ok = win_ok(a);
      init_req = 1'b1;
      repeat (2) @(negedge clk);
      init_req = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_byte  = a[7:0];
      @(negedge clk);
      cmd_byte  = a[15:8];
      @(negedge clk);
      cmd_valid = 1'b0;
      if (ok) begin
         chk(busy === 1'b1 && error === 1'b0, "R7 busy after accept", int'(busy), 1);
         seen_done = 1'b0;
         for (int k = 0; k < 600 && !seen_done; k++) begin
            if (done === 1'b1) seen_done = 1'b1;
            else begin
               if (inject) begin
                  if (k == 2) begin cmd_valid = 1'b1; cmd_byte = 8'h12; end
                  if (k == 3) cmd_valid = 1'b0;
                  if (k == 6) begin cmd_valid = 1'b1; cmd_byte = 8'h00; end
                  if (k == 7) cmd_valid = 1'b0;
               end
               @(negedge clk);
            end
         end
         cmd_valid = 1'b0;
         chk(seen_done, "R7 done pulse", int'(seen_done), 1);
         chk(busy === 1'b1, "R7 busy during done", int'(busy), 1);
         @(negedge clk);
         chk(busy === 1'b0 && done === 1'b0, "R7 idle after done", int'({busy, done}), 0);
         bad = 0;
         first_bad = -1;
         for (int i = 1; i < 32; i++) begin
            if (regs[16 + i] !== mem[(int'(a) + i) % 256]) begin
               bad++;
               if (first_bad < 0) first_bad = i;
            end
         end
         chk(bad == 0, "R2 R5 register contents",
             (first_bad < 0) ? 0 : int'(regs[16 + first_bad]),
             (first_bad < 0) ? 0 : int'(mem[(int'(a) + first_bad) % 256]));
         chk(regs[16] === DEF_VAL, "R6 register 10h untouched", int'(regs[16]), int'(DEF_VAL));
         chk(wr_cnt == 31, "R6 write count", wr_cnt, 31);
         bad = 0;
         for (int i = 0; i < 32; i++) begin
            if (rd_log[i] !== a + 16'(i)) bad++;
         end
         chk(rd_cnt == 32 && bad == 0, "R4 read sequence", rd_cnt, 32);
         repeat (4) @(negedge clk);
         chk(busy === 1'b0 && rd_cnt == 32, "R8 no restart from dropped bytes", rd_cnt, 32);
      end else begin
         chk(error === 1'b1 && busy === 1'b0, "R3 error pulse", int'({error, busy}), 2);
         @(negedge clk);
         chk(error === 1'b0, "R3 error one cycle", int'(error), 0);
         repeat (6) @(negedge clk);
         chk(rd_cnt == 0 && wr_cnt == 0 && busy === 1'b0, "R3 nothing read or written",
             rd_cnt + wr_cnt, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] a;
      void'($urandom(32'd31));
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'($urandom);
         if (mem[i] == DEF_VAL) mem[i] = ~DEF_VAL;
      end
      for (int i = 0; i < 64; i++) regs[i] = DEF_VAL;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      // R1: quiet after reset, defaults untouched
      chk(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R1 reset outputs",
          int'({busy, done, error}), 0);
      chk(rd_cnt == 0 && wr_cnt == 0 && regs[16] === DEF_VAL, "R1 no activity without command",
          rd_cnt + wr_cnt, 0);
      // R9 window edges
      run_cmd(16'h0030, 1'b0);
      run_cmd(16'h0060, 1'b0);
      run_cmd(16'h002F, 1'b0);
      run_cmd(16'h0061, 1'b0);
      // R3 wrap-around and byte order (swapped bytes land outside window)
      run_cmd(16'hFFF0, 1'b0);
      run_cmd(16'h4000, 1'b0);
      // R8 bytes during busy, then a fresh command
      run_cmd(16'h0040, 1'b1);
      run_cmd(16'h0050, 1'b0);
      // constrained random start addresses around the window
      for (int n = 0; n < 16; n++) begin
         a = 16'($urandom_range(32, 112));
         run_cmd(a, n[0]);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule